// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between a host bus and the write engine of a boot-block flash device. The host issues single-cycle bus writes that carry command bytes. The decoder reads those bytes and picks what later bus reads return: the memory array, a pair of fixed identifier codes, or an eight-bit status register. Program and block-erase operations need two writes. A setup byte comes first. A second write then supplies the target location, and also the data for a program. After both writes the decoder sends a one-cycle request to the write engine.

While the engine is working, the decoder accepts only a narrow set of commands. During a program it accepts just the status-read command. During an erase it accepts status-read and erase-suspend. A suspended erase allows reads of any source and can be resumed. When the engine reports completion, the full command set is accepted again, but the read source does not change until the host writes a new command. No operation is launched unless the programming-voltage-valid input is high. Failures are recorded in sticky status bits.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After reset, reads return the array. A write of 0xFF selects the array, 0x90 selects the identifier and 0x70 selects the status register. The selected source persists across any number of reads.
- R2: In identifier mode only address bit 0 is decoded: 0 returns 0x0089, and 1 returns 0x2274 (0x2275 when BOTTOM_BOOT=1). When byte_mode=1, only the low byte is returned, the upper byte reads 0, and byte_sel has no effect.
- R3: In array mode with byte_mode=0, rdata equals arr_rdata. With byte_mode=1, rdata[7:0] is the low byte (byte_sel=0) or the high byte (byte_sel=1) of arr_rdata, and rdata[15:8]=0.
- R4: A write of 0x40 or 0x10 enters program setup and selects status reads. The next write, with vpp_ok=1, makes eng_req high for exactly the one cycle after that write's clock edge. In that cycle eng_erase=0 and eng_addr/eng_wdata hold that write's address and data.
- R5: A write of 0x20 followed by a write of 0xD0 (vpp_ok=1) raises eng_req for one cycle, with eng_erase=1 and eng_addr equal to the address of the 0xD0 write.
- R6: The status byte occupies rdata[7:0] with rdata[15:8]=0. Its layout is bit7 ready, bit6 erase suspended, bit5 erase error, bit4 program error, bit3 voltage error, and bits 2:0 zero. During a program, ready=0 and every command except 0x70 is ignored.
- R7: During an erase, 0xB0 raises eng_pause and makes the status read 0xC0. While suspended, 0xFF, 0x90 and 0x70 change the read source. 0xD0 resumes the erase: eng_pause drops and ready returns to 0.
- R8: When eng_done is pulsed during a program or an erase, ready returns to 1 and the read source is unchanged. After that, the full command set is accepted again.
- R9: If vpp_ok=0 when a program or erase would launch, there is no request. Bit3 is set, together with bit4 (program) or bit5 (erase), and the decoder returns to the idle state.
- R10: After 0x20, any write other than 0xD0 launches nothing, sets bit5, and leaves the read source on status.
- R11: 0x50 clears bits 5:3 and keeps the read source. 0x00 and undefined codes, and also 0xD0 and 0xB0 outside their states, have no effect.
- R12: rdata_oe is 1 only when ce_n=0, oe_n=0 and we_n=1. Otherwise the data outputs are treated as released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write strobe, active low; a write is sampled on each edge where ce_n and we_n are both low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Word address |
| byte_sel | input | 1 | Extra low address bit used in byte mode |
| byte_mode | input | 1 | 1 = 8-bit data path |
| wdata | input | 16 | Write data; the command byte is bits 7:0 |
| vpp_ok | input | 1 | Programming voltage is within range |
| eng_done | input | 1 | One-cycle completion pulse from the write engine |
| eng_req | output | 1 | One-cycle launch request |
| eng_erase | output | 1 | 1 = block erase, 0 = program |
| eng_addr | output | ADDR_W | Target address of the request |
| eng_wdata | output | 16 | Program data |
| eng_pause | output | 1 | Holds the engine while an erase is suspended |
| arr_addr | output | ADDR_W | Array read address |
| arr_rdata | input | 16 | Array read data |
| rd_src | output | 2 | Current read source: 0 array, 1 identifier, 2 status |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Data outputs driven |

## Verification
The hardest state to reach from the ports is a suspended erase in which the read source has been moved away from status and then resumed. Reaching it needs a valid erase setup, a confirm, an engine that stays busy, a suspend, a change of read source, and a resume, all in order. The bench acts as the write engine itself and delays the done pulse until that whole sequence has been played. Error paths are reached by dropping vpp_ok just before the launching write, or by sending a non-confirm byte after erase setup.

// File: rtl/fcd_pkg.sv
package fcd_pkg;
  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PSETUP, ST_ESETUP, ST_PBUSY, ST_EBUSY, ST_ESUSP
  } fcd_state_e;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_IDENT  = 2'd1,
    RD_STATUS = 2'd2
  } fcd_rd_e;

  localparam logic [7:0] CMD_READ    = 8'hFF;
  localparam logic [7:0] CMD_IDENT   = 8'h90;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_CLEAR   = 8'h50;
  localparam logic [7:0] CMD_PROG_A  = 8'h40;
  localparam logic [7:0] CMD_PROG_B  = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h20;
  localparam logic [7:0] CMD_CONFIRM = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND = 8'hB0;

  localparam logic [15:0] MFR_CODE = 16'h0089;
  localparam logic [15:0] DEV_TOP  = 16'h2274;
  localparam logic [15:0] DEV_BOT  = 16'h2275;
endpackage

// File: rtl/fcd_rst_sync.sv
module fcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/fcd_cmd_fsm.sv
module fcd_cmd_fsm
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vpp_ok,
  input  logic              eng_done,
  output fcd_rd_e           rd_mode,
  output logic              eng_req,
  output logic              eng_erase,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [DATA_W-1:0] eng_wdata,
  output logic              eng_pause,
  output logic              ready,
  output logic              set_prog_err,
  output logic              set_erase_err,
  output logic              set_vpp_err,
  output logic              clr_err
);
  fcd_state_e        state_q, state_d;
  fcd_rd_e           mode_q, mode_d;
  logic              req_q, req_d;
  logic              erase_q, erase_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic [7:0]        cmd;

  assign cmd = wr_data[7:0];

  always_comb begin
    state_d       = state_q;
    mode_d        = mode_q;
    req_d         = 1'b0;
    erase_d       = erase_q;
    addr_d        = addr_q;
    data_d        = data_q;
    set_prog_err  = 1'b0;
    set_erase_err = 1'b0;
    set_vpp_err   = 1'b0;
    clr_err       = 1'b0;
    case (state_q)
      ST_IDLE, ST_ESUSP: begin
        if (wr_stb) begin
          case (cmd)
            CMD_READ:   mode_d = RD_ARRAY;
            CMD_IDENT:  mode_d = RD_IDENT;
            CMD_STATUS: mode_d = RD_STATUS;
            CMD_CLEAR:  clr_err = 1'b1;
            CMD_PROG_A, CMD_PROG_B: begin
              if (state_q == ST_IDLE) begin
                state_d = ST_PSETUP;
                mode_d  = RD_STATUS;
              end
            end
            CMD_ERASE: begin
              if (state_q == ST_IDLE) begin
                state_d = ST_ESETUP;
                mode_d  = RD_STATUS;
              end
            end
            CMD_CONFIRM: begin
              if (state_q == ST_ESUSP) state_d = ST_EBUSY;
            end
            default: ;
          endcase
        end
      end
      ST_PSETUP: begin
        if (wr_stb) begin
          mode_d = RD_STATUS;
          if (vpp_ok) begin
            req_d   = 1'b1;
            erase_d = 1'b0;
            addr_d  = wr_addr;
            data_d  = wr_data;
            state_d = ST_PBUSY;
          end else begin
            set_prog_err = 1'b1;
            set_vpp_err  = 1'b1;
            state_d      = ST_IDLE;
          end
        end
      end
      ST_ESETUP: begin
        if (wr_stb) begin
          mode_d = RD_STATUS;
          if (cmd == CMD_CONFIRM && vpp_ok) begin
            req_d   = 1'b1;
            erase_d = 1'b1;
            addr_d  = wr_addr;
            state_d = ST_EBUSY;
          end else begin
            set_erase_err = 1'b1;
            set_vpp_err   = (cmd == CMD_CONFIRM);
            state_d       = ST_IDLE;
          end
        end
      end
      ST_PBUSY: begin
        if (eng_done) state_d = ST_IDLE;
        else if (wr_stb && cmd == CMD_STATUS) mode_d = RD_STATUS;
      end
      ST_EBUSY: begin
        if (eng_done) state_d = ST_IDLE;
        else if (wr_stb) begin
          if (cmd == CMD_STATUS)  mode_d  = RD_STATUS;
          if (cmd == CMD_SUSPEND) state_d = ST_ESUSP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= RD_ARRAY;
      req_q   <= 1'b0;
      erase_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      req_q   <= req_d;
      erase_q <= erase_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
    end
  end

  assign rd_mode   = mode_q;
  assign eng_req   = req_q;
  assign eng_erase = erase_q;
  assign eng_addr  = addr_q;
  assign eng_wdata = data_q;
  assign eng_pause = (state_q == ST_ESUSP);
  assign ready     = (state_q != ST_PBUSY) && (state_q != ST_EBUSY);

  // R4: launch request lasts one cycle
  p_req_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |=> !eng_req);
  // R9: no launch without valid programming voltage
  p_req_vpp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req |-> $past(vpp_ok));
  // R8: completion leaves the read source alone
  p_done_keeps_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_done && !ready) |=> rd_mode == $past(rd_mode));
  // R6: non-status commands during a program do not move the read source
  p_pbusy_filter_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PBUSY && !eng_done && wr_stb && cmd != CMD_STATUS)
      |=> rd_mode == $past(rd_mode));
endmodule

// File: rtl/fcd_status.sv
module fcd_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ready,
  input  logic       suspended,
  input  logic       set_prog_err,
  input  logic       set_erase_err,
  input  logic       set_vpp_err,
  input  logic       clr_err,
  output logic [7:0] status_byte
);
  logic prog_err_q, erase_err_q, vpp_err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_err_q  <= 1'b0;
      erase_err_q <= 1'b0;
      vpp_err_q   <= 1'b0;
    end else if (clr_err) begin
      prog_err_q  <= 1'b0;
      erase_err_q <= 1'b0;
      vpp_err_q   <= 1'b0;
    end else begin
      if (set_prog_err)  prog_err_q  <= 1'b1;
      if (set_erase_err) erase_err_q <= 1'b1;
      if (set_vpp_err)   vpp_err_q   <= 1'b1;
    end
  end

  assign status_byte = {ready, suspended, erase_err_q, prog_err_q, vpp_err_q, 3'b000};

  // R11: clear empties all error bits
  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err |=> (status_byte[5:3] == 3'b000));
  // R9: error bits are sticky until cleared
  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (status_byte[4] && !clr_err) |=> status_byte[4]);
endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
  import fcd_pkg::*;
#(
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  fcd_rd_e           rd_mode,
  input  logic              addr_lsb,
  input  logic              byte_mode,
  input  logic              byte_sel,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic [7:0]        status_byte,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] dev_code;
  logic [DATA_W-1:0] id_word;
  logic [DATA_W-1:0] arr_word;

  generate
    if (BOTTOM_BOOT) begin : g_bot
      assign dev_code = DEV_BOT;
    end else begin : g_top
      assign dev_code = DEV_TOP;
    end
  endgenerate

  always_comb begin
    id_word = addr_lsb ? dev_code : MFR_CODE;
    if (byte_mode) id_word = {8'h00, id_word[7:0]};
    arr_word = arr_rdata;
    if (byte_mode) arr_word = {8'h00, byte_sel ? arr_rdata[15:8] : arr_rdata[7:0]};
    case (rd_mode)
      RD_IDENT:  rdata = id_word;
      RD_STATUS: rdata = {8'h00, status_byte};
      default:   rdata = arr_word;
    endcase
  end
endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter bit BOTTOM_BOOT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              byte_sel,
  input  logic              byte_mode,
  input  logic [15:0]       wdata,
  input  logic              vpp_ok,
  input  logic              eng_done,
  output logic              eng_req,
  output logic              eng_erase,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [15:0]       eng_wdata,
  output logic              eng_pause,
  output logic [ADDR_W-1:0] arr_addr,
  input  logic [15:0]       arr_rdata,
  output logic [1:0]        rd_src,
  output logic [15:0]       rdata,
  output logic              rdata_oe
);
  logic    rst_n_sync;
  logic    wr_stb;
  fcd_rd_e rd_mode;
  logic    ready, set_prog_err, set_erase_err, set_vpp_err, clr_err;
  logic [7:0] status_byte;

  assign wr_stb   = !ce_n && !we_n;
  assign rdata_oe = !ce_n && !oe_n && we_n;
  assign arr_addr = addr;
  assign rd_src   = rd_mode;

  fcd_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  fcd_cmd_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_sync), .wr_stb(wr_stb), .wr_addr(addr),
    .wr_data(wdata), .vpp_ok(vpp_ok), .eng_done(eng_done),
    .rd_mode(rd_mode), .eng_req(eng_req), .eng_erase(eng_erase),
    .eng_addr(eng_addr), .eng_wdata(eng_wdata), .eng_pause(eng_pause),
    .ready(ready), .set_prog_err(set_prog_err), .set_erase_err(set_erase_err),
    .set_vpp_err(set_vpp_err), .clr_err(clr_err)
  );

  fcd_status u_status (
    .clk(clk), .rst_n(rst_n_sync), .ready(ready), .suspended(eng_pause),
    .set_prog_err(set_prog_err), .set_erase_err(set_erase_err),
    .set_vpp_err(set_vpp_err), .clr_err(clr_err), .status_byte(status_byte)
  );

  fcd_read_mux #(.BOTTOM_BOOT(BOTTOM_BOOT)) u_mux (
    .rd_mode(rd_mode), .addr_lsb(addr[0]), .byte_mode(byte_mode),
    .byte_sel(byte_sel), .arr_rdata(arr_rdata), .status_byte(status_byte),
    .rdata(rdata)
  );

  // R12: outputs never driven during a write strobe
  p_oe_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n_sync)
    wr_stb |-> !rdata_oe);
endmodule

// File: tb/sim_flash_cmd_decoder.sv
module sim_flash_cmd_decoder;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, byte_sel, byte_mode, vpp_ok, eng_done;
  logic [AW-1:0] addr;
  logic [15:0] wdata;
  logic eng_req, eng_erase, eng_pause, rdata_oe;
  logic [AW-1:0] eng_addr, arr_addr;
  logic [15:0] eng_wdata, arr_rdata, rdata;
  logic [1:0] rd_src;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  assign arr_rdata = {arr_addr[7:0] ^ 8'hA5, arr_addr[7:0]};

  flash_cmd_decoder #(.ADDR_W(AW), .BOTTOM_BOOT(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .byte_sel(byte_sel), .byte_mode(byte_mode), .wdata(wdata),
    .vpp_ok(vpp_ok), .eng_done(eng_done), .eng_req(eng_req),
    .eng_erase(eng_erase), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
    .eng_pause(eng_pause), .arr_addr(arr_addr), .arr_rdata(arr_rdata),
    .rd_src(rd_src), .rdata(rdata), .rdata_oe(rdata_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [15:0] d);
    @(negedge clk);
    ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic bs, output logic [15:0] v);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a; byte_sel = bs;
    #1 v = rdata;
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic done_pulse();
    @(negedge clk); eng_done = 1'b1;
    @(negedge clk); eng_done = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    @(negedge clk);
    check("R12 oe idle", {31'd0, rdata_oe}, 32'd0);
    check("R1 reset source", {30'd0, rd_src}, 32'd0);
    bus_read(17'h00012, 1'b0, v);
    check("R1 reset array read", {16'd0, v}, 32'h0000B712);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    bus_write(17'h0, 16'h0090);
    bus_read(17'h0, 1'b0, v);  check("R2 mfr code", {16'd0, v}, 32'h0089);
    bus_read(17'h1, 1'b0, v);  check("R2 dev code", {16'd0, v}, 32'h2274);
    bus_read(17'h3, 1'b0, v);  check("R1 ident persists", {16'd0, v}, 32'h2274);
    byte_mode = 1'b1;
    bus_read(17'h1, 1'b1, v);  check("R2 byte dev sel1", {16'd0, v}, 32'h0074);
    bus_read(17'h1, 1'b0, v);  check("R2 byte dev sel0", {16'd0, v}, 32'h0074);
    bus_read(17'h0, 1'b1, v);  check("R2 byte mfr", {16'd0, v}, 32'h0089);
    byte_mode = 1'b0;
  endtask

  task automatic t_array();
    logic [15:0] v;
    bus_write(17'h0, 16'h00FF);
    bus_read(17'h00034, 1'b0, v); check("R3 word", {16'd0, v}, 32'h9134);
    byte_mode = 1'b1;
    bus_read(17'h00034, 1'b0, v); check("R3 byte low", {16'd0, v}, 32'h0034);
    bus_read(17'h00034, 1'b1, v); check("R3 byte high", {16'd0, v}, 32'h0091);
    byte_mode = 1'b0;
    bus_write(17'h0, 16'h0070);
    bus_read(17'h0, 1'b0, v); check("R1 status select", {16'd0, v}, 32'h0080);
  endtask

  task automatic t_program(input logic [7:0] setup);
    logic [15:0] v;
    bus_write(17'h0, 16'h00FF);
    bus_write(17'h0, {8'h00, setup});
    check("R4 status after setup", {30'd0, rd_src}, 32'd2);
    bus_write(17'h00123, 16'hBEEF);
    check("R4 req", {31'd0, eng_req}, 32'd1);
    check("R4 op", {31'd0, eng_erase}, 32'd0);
    check("R4 addr", {15'd0, eng_addr}, 32'h00123);
    check("R4 data", {16'd0, eng_wdata}, 32'hBEEF);
    @(negedge clk);
    check("R4 req single", {31'd0, eng_req}, 32'd0);
    bus_read(17'h0, 1'b0, v); check("R6 busy status", {16'd0, v}, 32'h0000);
    bus_write(17'h0, 16'h00FF);
    bus_read(17'h0, 1'b0, v); check("R6 FF ignored busy", {16'd0, v}, 32'h0000);
    bus_write(17'h0, 16'h0090);
    check("R6 90 ignored busy", {30'd0, rd_src}, 32'd2);
    done_pulse();
    bus_read(17'h0, 1'b0, v); check("R8 ready kept status", {16'd0, v}, 32'h0080);
    bus_write(17'h0, 16'h0090);
    bus_read(17'h1, 1'b0, v); check("R8 full set back", {16'd0, v}, 32'h2274);
  endtask

  task automatic t_erase();
    logic [15:0] v;
    bus_write(17'h0, 16'h0020);
    bus_write(17'h00400, 16'h00D0);
    check("R5 req", {31'd0, eng_req}, 32'd1);
    check("R5 erase op", {31'd0, eng_erase}, 32'd1);
    check("R5 addr", {15'd0, eng_addr}, 32'h00400);
    bus_read(17'h0, 1'b0, v); check("R5 busy", {16'd0, v}, 32'h0000);
    bus_write(17'h0, 16'h00B0);
    check("R7 pause", {31'd0, eng_pause}, 32'd1);
    bus_read(17'h0, 1'b0, v); check("R7 susp status", {16'd0, v}, 32'h00C0);
    bus_write(17'h0, 16'h00FF);
    bus_read(17'h00056, 1'b0, v); check("R7 array in susp", {16'd0, v}, 32'hF356);
    bus_write(17'h0, 16'h0070);
    bus_write(17'h0, 16'h00D0);
    check("R7 resume pause", {31'd0, eng_pause}, 32'd0);
    bus_read(17'h0, 1'b0, v); check("R7 resumed busy", {16'd0, v}, 32'h0000);
    done_pulse();
    bus_read(17'h0, 1'b0, v); check("R8 erase done", {16'd0, v}, 32'h0080);
  endtask

  task automatic t_vpp();
    logic [15:0] v;
    vpp_ok = 1'b0;
    bus_write(17'h0, 16'h0040);
    bus_write(17'h00010, 16'h1234);
    check("R9 no prog req", {31'd0, eng_req}, 32'd0);
    bus_read(17'h0, 1'b0, v); check("R9 prog vpp status", {16'd0, v}, 32'h0098);
    bus_write(17'h0, 16'h0050);
    bus_read(17'h0, 1'b0, v); check("R11 clear", {16'd0, v}, 32'h0080);
    bus_write(17'h0, 16'h0020);
    bus_write(17'h0, 16'h00D0);
    check("R9 no erase req", {31'd0, eng_req}, 32'd0);
    bus_read(17'h0, 1'b0, v); check("R9 erase vpp status", {16'd0, v}, 32'h00A8);
    vpp_ok = 1'b1;
    bus_write(17'h0, 16'h0050);
  endtask

  task automatic t_bad_confirm();
    logic [15:0] v;
    bus_write(17'h0, 16'h0020);
    bus_write(17'h0, 16'h00FF);
    check("R10 no req", {31'd0, eng_req}, 32'd0);
    bus_read(17'h0, 1'b0, v); check("R10 error status", {16'd0, v}, 32'h00A0);
    bus_write(17'h0, 16'h0050);
    bus_read(17'h0, 1'b0, v); check("R11 clear keeps status", {16'd0, v}, 32'h0080);
  endtask

  task automatic t_ignore();
    logic [15:0] v;
    bus_write(17'h0, 16'h00FF);
    bus_write(17'h0, 16'h0000);
    bus_write(17'h0, 16'h0033);
    bus_write(17'h0, 16'h00D0);
    bus_write(17'h0, 16'h00B0);
    check("R11 no req from junk", {31'd0, eng_req}, 32'd0);
    bus_read(17'h00021, 1'b0, v); check("R11 junk ignored", {16'd0, v}, 32'h8421);
  endtask

  task automatic t_oe();
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    #1 check("R12 oe on", {31'd0, rdata_oe}, 32'd1);
    ce_n = 1'b1;
    #1 check("R12 ce high", {31'd0, rdata_oe}, 32'd0);
    ce_n = 1'b0; oe_n = 1'b1;
    #1 check("R12 oe high", {31'd0, rdata_oe}, 32'd0);
    ce_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; addr = '0;
    byte_sel = 1'b0; byte_mode = 1'b0; wdata = '0; vpp_ok = 1'b1; eng_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ident();
    t_array();
    t_program(8'h40);
    t_program(8'h10);
    t_erase();
    t_vpp();
    t_bad_confirm();
    t_ignore();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule